// File: doc/BRIEF.md
# Converter Status Tracker

This block sits at the output stage of a decimating sigma-delta filter and keeps its status flags. The filter core delivers each new 24-bit result with a strobe and two overflow indications. The block registers the result as the output word. If the accumulator overflowed, it substitutes the full-scale code of the matching sign. It also tracks the error conditions that a host reads back through a 24-bit status word and sees on an active-low error pin.

The block also keeps a "settled" flag. The flag drops whenever the filter history becomes invalid: after reset, on a sync pulse, when the gain, bandwidth or input-select setting changes, when power-down ends, and when the modulator overrange flag rises. The flag returns after a parameterised number of fresh results. While it is low, the error and range bits hold their values, so that transients from the restart cannot raise false alarms.

A separate range detector watches for long runs of results near full scale. It raises an out-of-range bit when four results in a row lie beyond three quarters of full scale on the same side.

Top module: `cvt_status_track`

## Requirements
- R1: `err_n` is the inverse of status bit 23 (error). Bit 23 is the OR of overwrite (bit 22), modulator flag (bit 21) and accumulator error (bit 19).
- R2: A synchronous reset clears overwrite, accumulator error, out-of-range, data-ready, settled and the output word. A one-cycle `stat_rd_done` pulse clears overwrite, accumulator error and out-of-range at the next edge, and this clear wins over a freeze or a new set in that same cycle.
- R3: Data-ready (bit 18) sets on each accepted result and clears on `rd_done`. Overwrite (bit 22) sets when a result arrives while a read is in progress, that is, after `rd_start` and before `rd_done`, provided the settled flag is high.
- R4: When the settled flag is high and power-down is off, the modulator flag (bit 21) takes the value of `ovr_in` at each rising clock edge. During power-down it holds its value, and reset clears it.
- R5: With `ovf_pos` the output word becomes 0x7FFFFF. With `ovf_neg` alone it becomes 0x800000. Either overflow sets accumulator error (bit 19) when the settled flag is high. `ovf_pos` takes priority when both overflow inputs are set.
- R6: Settled (bit 17) goes low at the edge that sees any of these: reset, `sync_ev`, a change of gain, bandwidth or input select, a falling `pwrdn_in`, or a rise of the modulator flag. It goes high again at the edge of the SETTLE_N-th result after that event.
- R7: While settled is low, overwrite, modulator flag, accumulator error and out-of-range do not change, except for the clears of R2.
- R8: Out-of-range (bit 16) sets, when settled is high, on the fourth consecutive result that is greater than +6291455 or less than -6291456, with all four on the same side. A result inside the limits, or one beyond the opposite limit, restarts the run.
- R9: The status word has power-down at bit 11, input select at bit 10, bandwidth at bits 8:6 and gain/input code at bits 4:0. Each field is registered one edge after its input. All unlisted bits read zero.
- R10: Without overflow, the output word equals the incoming result, registered at the edge of its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Strobe: new filter result |
| res_word | input | 24 | Two's-complement filter result |
| ovf_pos | input | 1 | Positive accumulator overflow with this result |
| ovf_neg | input | 1 | Negative accumulator overflow with this result |
| ovr_in | input | 1 | Modulator overrange level |
| sync_ev | input | 1 | Sync pulse restarting the filter |
| pwrdn_in | input | 1 | Power-down level |
| cfg_gain | input | 5 | Gain and input code |
| cfg_bw | input | 3 | Bandwidth code |
| cfg_isel | input | 1 | Filter input select |
| rd_start | input | 1 | Serial read of the result started |
| rd_done | input | 1 | Serial read of the result finished |
| stat_rd_done | input | 1 | Serial read of the status word finished |
| out_word | output | 24 | Registered, clipped output word |
| status_word | output | 24 | Status flags and configuration fields |
| err_n | output | 1 | Active-low error output |

## Verification
The assertions assume that the control strobes are single-cycle pulses, that `rd_start` and `rd_done` alternate, and that no result arrives during power-down. The bench drives every input at the falling clock edge and keeps each strobe high for exactly one cycle, so all of these assumptions hold. The bench places results just inside and just outside both range limits, breaks runs both with in-range values and with sign changes, and raises overflow and overrange both while the block is settled and while it is not, so that the freeze of R7 is seen at the ports.

// File: rtl/cst_pkg.sv
package cst_pkg;
    localparam int DATA_W = 24;
    localparam int STAT_W = 24;

    typedef logic signed [DATA_W-1:0] sample_t;

    localparam sample_t POS_FS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam sample_t NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};
    localparam sample_t HI_LIM = sample_t'((3 << (DATA_W-3)) - 1);
    localparam sample_t LO_LIM = sample_t'(-(3 << (DATA_W-3)));

    typedef enum logic [1:0] {RNG_IN, RNG_HI, RNG_LO} rng_e;

    typedef struct packed {
        logic       pwrdn;
        logic       isel;
        logic [2:0] bw;
        logic [4:0] gain;
    } cfg_t;

    function automatic sample_t clip_word(sample_t raw, logic op, logic on);
        if (op)      return POS_FS;
        else if (on) return NEG_FS;
        else         return raw;
    endfunction

    function automatic rng_e classify(sample_t v);
        if (v > HI_LIM)      return RNG_HI;
        else if (v < LO_LIM) return RNG_LO;
        else                 return RNG_IN;
    endfunction
endpackage

// File: rtl/cst_settle.sv
module cst_settle #(
    parameter int SETTLE_N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  logic res_valid,
    output logic settled
);
    localparam int CW = $clog2(SETTLE_N + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            settled <= 1'b0;
            cnt     <= '0;
        end else if (!settled && res_valid) begin
            if (cnt == CW'(SETTLE_N - 1)) begin
                settled <= 1'b1;
                cnt     <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/cst_range.sv
module cst_range
    import cst_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    res_valid,
    input  sample_t word,
    output logic    run_hit
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] run_len, nxt_len;
    rng_e          run_dir, cls;

    always_comb begin
        cls = classify(word);
        if (cls == RNG_IN)
            nxt_len = '0;
        else if (cls != run_dir || run_len == '0)
            nxt_len = CW'(1);
        else if (run_len == CW'(RUN_LEN))
            nxt_len = run_len;
        else
            nxt_len = run_len + CW'(1);
        run_hit = res_valid && (nxt_len == CW'(RUN_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            run_dir <= RNG_IN;
        end else if (res_valid) begin
            run_len <= nxt_len;
            run_dir <= cls;
        end
    end
endmodule

// File: rtl/cvt_status_track.sv
module cvt_status_track
    import cst_pkg::*;
#(
    parameter int SETTLE_N = 8,
    parameter int RUN_LEN  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_word,
    input  logic              ovf_pos,
    input  logic              ovf_neg,
    input  logic              ovr_in,
    input  logic              sync_ev,
    input  logic              pwrdn_in,
    input  logic [4:0]        cfg_gain,
    input  logic [2:0]        cfg_bw,
    input  logic              cfg_isel,
    input  logic              rd_start,
    input  logic              rd_done,
    input  logic              stat_rd_done,
    output logic [DATA_W-1:0] out_word,
    output logic [STAT_W-1:0] status_word,
    output logic              err_n
);
    cfg_t    cfg_q;
    sample_t clipped;
    logic    settled, frozen, kill, run_hit;
    logic    modf, mod_next, mod_rise;
    logic    ovw, acc, oor, drdy, rd_busy, err;
    logic    cfg_chg, pwr_exit;

    assign clipped  = clip_word(sample_t'(res_word), ovf_pos, ovf_neg);
    assign frozen   = !settled;
    assign mod_next = (frozen || pwrdn_in) ? modf : ovr_in;
    assign mod_rise = mod_next && !modf;
    assign cfg_chg  = (cfg_q.gain != cfg_gain) || (cfg_q.bw != cfg_bw) ||
                      (cfg_q.isel != cfg_isel);
    assign pwr_exit = cfg_q.pwrdn && !pwrdn_in;
    assign kill     = sync_ev || cfg_chg || pwr_exit || mod_rise;

    cst_settle #(.SETTLE_N(SETTLE_N)) settle_i (
        .clk(clk), .rst(rst), .kill(kill), .res_valid(res_valid),
        .settled(settled)
    );

    cst_range #(.RUN_LEN(RUN_LEN)) range_i (
        .clk(clk), .rst(rst), .res_valid(res_valid), .word(clipped),
        .run_hit(run_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            out_word <= '0;
            modf     <= 1'b0;
            drdy     <= 1'b0;
            rd_busy  <= 1'b0;
        end else begin
            cfg_q <= '{pwrdn: pwrdn_in, isel: cfg_isel, bw: cfg_bw, gain: cfg_gain};
            modf  <= mod_next;
            if (res_valid) out_word <= clipped;
            if (res_valid)    drdy <= 1'b1;
            else if (rd_done) drdy <= 1'b0;
            if (rd_start)     rd_busy <= 1'b1;
            else if (rd_done) rd_busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || stat_rd_done) begin
            ovw <= 1'b0;
            acc <= 1'b0;
            oor <= 1'b0;
        end else if (!frozen && res_valid) begin
            if (rd_busy)            ovw <= 1'b1;
            if (ovf_pos || ovf_neg) acc <= 1'b1;
            if (run_hit)            oor <= 1'b1;
        end
    end

    assign err   = ovw || modf || acc;
    assign err_n = !err;

    always_comb begin
        status_word      = '0;
        status_word[23]  = err;
        status_word[22]  = ovw;
        status_word[21]  = modf;
        status_word[19]  = acc;
        status_word[18]  = drdy;
        status_word[17]  = settled;
        status_word[16]  = oor;
        status_word[11]  = cfg_q.pwrdn;
        status_word[10]  = cfg_q.isel;
        status_word[8:6] = cfg_q.bw;
        status_word[4:0] = cfg_q.gain;
    end
endmodule

module cst_checker
    import cst_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              res_valid,
    input logic              ovf_pos,
    input logic              ovf_neg,
    input logic              sync_ev,
    input logic              pwrdn_in,
    input logic              stat_rd_done,
    input logic              rd_busy,
    input logic              settled,
    input logic [DATA_W-1:0] out_word,
    input logic [STAT_W-1:0] status_word,
    input logic              err_n
);
    AST_ERR_PIN: assert property (@(posedge clk) disable iff (rst)
        err_n == !status_word[23]);                                       // R1
    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        stat_rd_done |=> (!status_word[22] && !status_word[19] && !status_word[16])); // R2
    AST_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        (res_valid && rd_busy && settled && !stat_rd_done) |=> status_word[22]); // R3
    AST_DRDY_SET: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> status_word[18]);                                   // R3
    AST_MOD_PWRDN: assert property (@(posedge clk) disable iff (rst)
        pwrdn_in |=> $stable(status_word[21]));                          // R4
    AST_CLIP_POS: assert property (@(posedge clk) disable iff (rst)
        (res_valid && ovf_pos) |=> out_word == POS_FS);                   // R5
    AST_CLIP_NEG: assert property (@(posedge clk) disable iff (rst)
        (res_valid && ovf_neg && !ovf_pos) |=> out_word == NEG_FS);       // R5
    AST_SYNC_UNSETTLE: assert property (@(posedge clk) disable iff (rst)
        sync_ev |=> !status_word[17]);                                    // R6
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!settled && !stat_rd_done) |=> ($stable(status_word[22]) &&
        $stable(status_word[21]) && $stable(status_word[19]) &&
        $stable(status_word[16])));                                       // R7
endmodule

bind cvt_status_track cst_checker chk_i (
    .clk(clk), .rst(rst), .res_valid(res_valid), .ovf_pos(ovf_pos),
    .ovf_neg(ovf_neg), .sync_ev(sync_ev), .pwrdn_in(pwrdn_in),
    .stat_rd_done(stat_rd_done), .rd_busy(rd_busy), .settled(settled),
    .out_word(out_word), .status_word(status_word), .err_n(err_n)
);

// File: tb/cvt_status_track_tb.sv
module cvt_status_track_tb_top;
    localparam int SN = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res_valid = 1'b0;
    logic [23:0] res_word = '0;
    logic        ovf_pos = 1'b0, ovf_neg = 1'b0, ovr_in = 1'b0;
    logic        sync_ev = 1'b0, pwrdn_in = 1'b0;
    logic [4:0]  cfg_gain = '0;
    logic [2:0]  cfg_bw = '0;
    logic        cfg_isel = 1'b0;
    logic        rd_start = 1'b0, rd_done = 1'b0, stat_rd_done = 1'b0;
    logic [23:0] out_word, status_word;
    logic        err_n;

    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cvt_status_track #(.SETTLE_N(SN), .RUN_LEN(4)) dut_i (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(int v, bit op = 0, bit on = 0);
        res_word  = 24'(v);
        ovf_pos   = op;
        ovf_neg   = on;
        res_valid = 1'b1;
        tick();
        res_valid = 1'b0;
        ovf_pos   = 1'b0;
        ovf_neg   = 1'b0;
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        tick();
        s = 1'b0;
    endtask

    task automatic resettle();
        for (int i = 0; i < SN; i++) send(0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R2", "status after reset", int'(status_word), 0);
        chk("R1", "err_n after reset", int'(err_n), 1);
        chk("R2", "out_word after reset", int'(out_word), 0);

        send(100);
        send(100);
        chk("R6", "unsettled before last result", int'(status_word[17]), 0);
        send(100);
        chk("R6", "settled after SETTLE_N results", int'(status_word[17]), 1);
        chk("R3", "data ready", int'(status_word[18]), 1);

        for (int i = 0; i < 16; i++) begin
            int v = (i - 8) * 700001;
            send(v);
            chk("R10", "output word sweep", int'(out_word), v & 32'hFFFFFF);
        end
        chk("R8", "in-range sweep no oor", int'(status_word[16]), 0);

        pulse(rd_done);
        chk("R3", "data ready cleared", int'(status_word[18]), 0);

        pulse(rd_start);
        send(7);
        chk("R3", "overwrite set", int'(status_word[22]), 1);
        chk("R1", "error bit on overwrite", int'(status_word[23]), 1);
        chk("R1", "err_n low on overwrite", int'(err_n), 0);
        pulse(stat_rd_done);
        chk("R2", "overwrite cleared by status read", int'(status_word[22]), 0);
        chk("R1", "err_n high after clear", int'(err_n), 1);
        pulse(rd_done);
        send(8);
        chk("R3", "no overwrite when idle", int'(status_word[22]), 0);

        send(5, 1, 0);
        chk("R5", "positive clip", int'(out_word), 32'h7FFFFF);
        chk("R5", "acc error set", int'(status_word[19]), 1);
        chk("R1", "err_n low on acc error", int'(err_n), 0);
        send(5, 0, 1);
        chk("R5", "negative clip", int'(out_word), 32'h800000);
        send(5, 1, 1);
        chk("R5", "positive wins", int'(out_word), 32'h7FFFFF);
        pulse(stat_rd_done);
        chk("R2", "acc error cleared", int'(status_word[19]), 0);
        send(0);

        for (int i = 0; i < 4; i++) send(6291455);
        chk("R8", "upper limit not beyond", int'(status_word[16]), 0);
        for (int i = 0; i < 3; i++) send(6291456);
        send(0);
        for (int i = 0; i < 3; i++) send(6291456);
        chk("R8", "broken run no oor", int'(status_word[16]), 0);
        send(6291456);
        chk("R8", "four beyond upper sets oor", int'(status_word[16]), 1);
        pulse(stat_rd_done);
        chk("R2", "oor cleared", int'(status_word[16]), 0);
        send(0);
        for (int i = 0; i < 4; i++) send(-6291456);
        chk("R8", "lower limit not beyond", int'(status_word[16]), 0);
        send(-6291457);
        send(-6291457);
        send(6291456);
        send(6291456);
        chk("R8", "sign change restarts run", int'(status_word[16]), 0);
        send(6291456);
        send(6291456);
        chk("R8", "four positive after sign change", int'(status_word[16]), 1);
        pulse(stat_rd_done);
        send(0);
        send(-8000000);
        send(-8000000);
        send(-8000000);
        chk("R8", "three below lower no oor", int'(status_word[16]), 0);
        send(-8000000);
        chk("R8", "four below lower sets oor", int'(status_word[16]), 1);
        pulse(stat_rd_done);
        send(0);

        ovr_in = 1'b1;
        tick();
        chk("R4", "mod flag follows overrange", int'(status_word[21]), 1);
        chk("R6", "mod rise unsettles", int'(status_word[17]), 0);
        chk("R1", "err_n low on mod flag", int'(err_n), 0);
        ovr_in = 1'b0;
        tick();
        chk("R7", "mod flag frozen", int'(status_word[21]), 1);
        send(1, 1, 0);
        chk("R7", "acc error frozen", int'(status_word[19]), 0);
        chk("R5", "clip still applied when frozen", int'(out_word), 32'h7FFFFF);
        send(0);
        send(0);
        chk("R6", "resettled", int'(status_word[17]), 1);
        tick();
        chk("R4", "mod flag follows low", int'(status_word[21]), 0);
        chk("R1", "err_n high", int'(err_n), 1);

        pwrdn_in = 1'b1;
        tick();
        chk("R9", "power-down field", int'(status_word[11]), 1);
        ovr_in = 1'b1;
        tick();
        tick();
        chk("R4", "mod flag held in power-down", int'(status_word[21]), 0);
        chk("R6", "settled during power-down", int'(status_word[17]), 1);
        pwrdn_in = 1'b0;
        ovr_in   = 1'b0;
        tick();
        chk("R6", "power-down exit unsettles", int'(status_word[17]), 0);
        resettle();

        cfg_gain = 5'h13;
        cfg_bw   = 3'b101;
        cfg_isel = 1'b1;
        tick();
        chk("R6", "config change unsettles", int'(status_word[17]), 0);
        chk("R9", "gain field", int'(status_word[4:0]), 32'h13);
        chk("R9", "bandwidth field", int'(status_word[8:6]), 5);
        chk("R9", "input select field", int'(status_word[10]), 1);
        chk("R9", "unused bits zero", int'({status_word[20], status_word[15:12], status_word[9], status_word[5]}), 0);
        resettle();
        chk("R6", "settled after config", int'(status_word[17]), 1);
        pulse(sync_ev);
        chk("R6", "sync unsettles", int'(status_word[17]), 0);
        resettle();
        send(3, 1, 0);
        chk("R5", "acc before reset", int'(status_word[19]), 1);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R2", "acc cleared by reset", int'(status_word[19]), 0);
        chk("R6", "reset unsettles", int'(status_word[17]), 0);
        chk("R2", "output cleared by reset", int'(out_word), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule